// File: doc/BRIEF.md
# Branch Opcode Type Classifier

This block labels a control-flow change after the fact. It takes the leading instruction bytes fetched from the source address, the rel32 displacement that follows a near-call opcode, the source and target addresses, and one privilege bit for each of the two ends. From these it produces a one-hot branch-kind vector. Every meaningful result also carries a bit that gives the privilege level of the target. A performance-monitoring filter can AND this vector with a mask of the kinds it wants and discard every record that does not match.

Some inputs make decoding impossible or pointless. These are an empty record (either address zero), a fetch that returned no bytes, and a record flagged as a transactional abort. Those cases are settled before the opcode is examined. A change from user level to kernel level that the opcode cannot explain is reported as a hardware interrupt, trap or fault. The result is registered by default, so it appears one cycle after the inputs. A parameter removes the register and leaves a purely combinational path.

Top module: `brk_classifier`

## Requirements
- R1: If `bytes_valid` is low, or `src_addr` is zero, or `dst_addr` is zero, the output is all zeros. This holds even when `abort_flag` is set.
- R2: With valid inputs and `abort_flag` high, the output is bit 12 (abort) plus the target privilege bit, and the opcode bytes are ignored.
- R3: When the first byte is 0F, the second byte selects the kind. 05 and 34 give bit 4 (system call). 07 and 35 give bit 5 (system return). 80 through 8F give bit 8 (conditional). Any other second byte gives no kind.
- R4: First bytes 70 through 7F and E0 through E3 give bit 8 (conditional).
- R5: First bytes C2, C3, CA and CB give bit 3 (return). CF gives bit 7 (interrupt return). CC, CD and CE give bit 6 (software interrupt).
- R6: First bytes E9, EA and EB give bit 9 (jump), and 9A gives bit 2 (call). E8 gives bit 15 (zero-length call) when `rel_imm` is zero, and bit 2 otherwise.
- R7: First byte FF uses bits 5:3 of `modrm_byte`. A value of 2 or 3 gives bit 11 (indirect call), 4 or 5 gives bit 17 (indirect jump), and any other value gives no kind.
- R8: With `src_kernel` low and `dst_kernel` high, any decode other than system call (bit 4) or software interrupt (bit 6) is replaced by bit 10 (interrupt/fault). This includes an unrecognised opcode.
- R9: Every non-zero output carries exactly one privilege bit. That bit is 1 (kernel) when `dst_kernel` is high and 0 (user) otherwise. No more than one kind bit among bits 2 to 17 is ever set.
- R10: An unrecognised opcode with no user-to-kernel transition gives an all-zero output, with no privilege bit.
- R11: With `REG_OUT` = 1, the output reflects the inputs present at the previous rising clock edge. While `rst_n` is low, the output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| bytes_valid | input | 1 | Instruction bytes were fetched successfully |
| op_first | input | 8 | First opcode byte |
| op_second | input | 8 | Second opcode byte (after 0F) |
| modrm_byte | input | 8 | ModRM byte following an FF opcode |
| rel_imm | input | IMM_W | rel32 displacement of a near call |
| src_addr | input | ADDR_W | Source address of the change |
| dst_addr | input | ADDR_W | Target address of the change |
| src_kernel | input | 1 | Source is at kernel privilege |
| dst_kernel | input | 1 | Target is at kernel privilege |
| abort_flag | input | 1 | Record marks a transaction abort |
| kind | output | 18 | Branch-kind vector with target privilege bit |

## Verification
Three rules can apply to one record at the same time. The invalid-record gate, the abort shortcut and the user-to-kernel override all compete with the opcode decode. Directed cases set `abort_flag` together with a zero address, pair user-to-kernel privilege with system-call, software-interrupt, jump and unknown opcodes, and pair an FF opcode with every ModRM field value. Random records mix all of these, weighted toward the listed opcodes. The expected kind is recomputed from the precedence order in the requirements: gate first, then abort, then decode, then override, then privilege.

// File: rtl/brk_pkg.sv
package brk_pkg;
    localparam int KIND_W     = 18;

    localparam int B_USER     = 0;
    localparam int B_KERNEL   = 1;
    localparam int B_CALL     = 2;
    localparam int B_RET      = 3;
    localparam int B_SYSENTER = 4;
    localparam int B_SYSEXIT  = 5;
    localparam int B_SWINT    = 6;
    localparam int B_INTRET   = 7;
    localparam int B_COND     = 8;
    localparam int B_JUMP     = 9;
    localparam int B_HWIRQ    = 10;
    localparam int B_INDCALL  = 11;
    localparam int B_ABORT    = 12;
    localparam int B_INTX     = 13;
    localparam int B_NOTX     = 14;
    localparam int B_ZCALL    = 15;
    localparam int B_CSTACK   = 16;
    localparam int B_INDJUMP  = 17;

    localparam logic [7:0] ESC_BYTE = 8'h0F;
    localparam logic [7:0] GRP_BYTE = 8'hFF;

    typedef logic [KIND_W-1:0] kind_t;

    typedef struct packed {
        kind_t kind;
    } res_t;
endpackage

// File: rtl/brk_opdecode.sv
module brk_opdecode
    import brk_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input  logic [7:0]       op_first,
    input  logic [7:0]       op_second,
    input  logic [7:0]       modrm_byte,
    input  logic [IMM_W-1:0] rel_imm,
    output kind_t            dec_kind
);
    localparam int REG_LO = 3;
    localparam int REG_HI = 5;

    logic [2:0] reg_field;
    logic       imm_zero;

    assign reg_field = modrm_byte[REG_HI:REG_LO];
    assign imm_zero  = (rel_imm == '0);

    always_comb begin
        dec_kind = '0;
        if (op_first == ESC_BYTE) begin
            case (op_second)
                8'h05, 8'h34: dec_kind[B_SYSENTER] = 1'b1;
                8'h07, 8'h35: dec_kind[B_SYSEXIT]  = 1'b1;
                default: begin
                    if (op_second[7:4] == 4'h8) dec_kind[B_COND] = 1'b1;
                end
            endcase
        end else begin
            case (op_first) inside
                [8'h70:8'h7F], [8'hE0:8'hE3]: dec_kind[B_COND] = 1'b1;
                8'hC2, 8'hC3, 8'hCA, 8'hCB:   dec_kind[B_RET] = 1'b1;
                8'hCF:                        dec_kind[B_INTRET] = 1'b1;
                [8'hCC:8'hCE]:                dec_kind[B_SWINT] = 1'b1;
                [8'hE9:8'hEB]:                dec_kind[B_JUMP] = 1'b1;
                8'h9A:                        dec_kind[B_CALL] = 1'b1;
                8'hE8: begin
                    if (imm_zero) dec_kind[B_ZCALL] = 1'b1;
                    else          dec_kind[B_CALL]  = 1'b1;
                end
                GRP_BYTE: begin
                    case (reg_field)
                        3'd2, 3'd3: dec_kind[B_INDCALL] = 1'b1;
                        3'd4, 3'd5: dec_kind[B_INDJUMP] = 1'b1;
                        default:    dec_kind = '0;
                    endcase
                end
                default: dec_kind = '0;
            endcase
        end
    end

    // at most one kind from the opcode table, never a privilege bit
    always_comb begin
        assert_decode_onehot_R9 : assert ($onehot0(dec_kind) && (dec_kind[B_KERNEL:B_USER] == 2'b00))
            else $error("decoder produced an illegal kind vector");
    end
endmodule

// File: rtl/brk_privmerge.sv
module brk_privmerge
    import brk_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  kind_t             dec_kind,
    input  logic              bytes_valid,
    input  logic              abort_flag,
    input  logic              src_kernel,
    input  logic              dst_kernel,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    output kind_t             kind_out
);
    logic  rec_ok;
    logic  up_cross;
    logic  explained;
    kind_t tgt_priv;
    kind_t body;

    assign rec_ok    = bytes_valid && (src_addr != '0) && (dst_addr != '0);
    assign up_cross  = !src_kernel && dst_kernel;
    assign explained = dec_kind[B_SYSENTER] || dec_kind[B_SWINT];

    always_comb begin
        tgt_priv = '0;
        if (dst_kernel) tgt_priv[B_KERNEL] = 1'b1;
        else            tgt_priv[B_USER]   = 1'b1;
    end

    always_comb begin
        body = dec_kind;
        if (up_cross && !explained) begin
            body = '0;
            body[B_HWIRQ] = 1'b1;
        end
    end

    always_comb begin
        kind_out = '0;
        if (rec_ok) begin
            if (abort_flag) begin
                kind_out = tgt_priv;
                kind_out[B_ABORT] = 1'b1;
            end else if (body != '0) begin
                kind_out = body | tgt_priv;
            end
        end
    end

    // a result without a kind never carries a privilege bit
    always_comb begin
        assert_no_bare_priv_R10 : assert ((kind_out[KIND_W-1:B_CALL] != '0) || (kind_out == '0))
            else $error("privilege bit without kind");
    end
endmodule

// File: rtl/brk_classifier.sv
module brk_classifier
    import brk_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int IMM_W   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bytes_valid,
    input  logic [7:0]          op_first,
    input  logic [7:0]          op_second,
    input  logic [7:0]          modrm_byte,
    input  logic [IMM_W-1:0]    rel_imm,
    input  logic [ADDR_W-1:0]   src_addr,
    input  logic [ADDR_W-1:0]   dst_addr,
    input  logic                src_kernel,
    input  logic                dst_kernel,
    input  logic                abort_flag,
    output logic [KIND_W-1:0]   kind
);
    kind_t dec_kind;
    kind_t merged;
    res_t  res_d;

    brk_opdecode #(.IMM_W(IMM_W)) u_dec (
        .op_first   (op_first),
        .op_second  (op_second),
        .modrm_byte (modrm_byte),
        .rel_imm    (rel_imm),
        .dec_kind   (dec_kind)
    );

    brk_privmerge #(.ADDR_W(ADDR_W)) u_merge (
        .dec_kind    (dec_kind),
        .bytes_valid (bytes_valid),
        .abort_flag  (abort_flag),
        .src_kernel  (src_kernel),
        .dst_kernel  (dst_kernel),
        .src_addr    (src_addr),
        .dst_addr    (dst_addr),
        .kind_out    (merged)
    );

    always_comb begin
        res_d      = '0;
        res_d.kind = merged;
    end

    generate
        if (REG_OUT) begin : g_reg
            res_t res_q;
            logic in_ok;

            always_ff @(posedge clk) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_d;
            end

            assign kind  = res_q.kind;
            assign in_ok = bytes_valid && (|src_addr) && (|dst_addr);

            assert_invalid_zero_R1 : assert property (@(posedge clk) disable iff (!rst_n)
                !in_ok |=> (kind == '0));

            assert_abort_only_R2 : assert property (@(posedge clk) disable iff (!rst_n)
                (in_ok && abort_flag) |=> (kind[B_ABORT] && $countones(kind) == 2));

            assert_cross_irq_R8 : assert property (@(posedge clk) disable iff (!rst_n)
                (in_ok && !abort_flag && !src_kernel && dst_kernel)
                |=> (kind[B_HWIRQ] || kind[B_SYSENTER] || kind[B_SWINT]));

            assert_priv_match_R9 : assert property (@(posedge clk) disable iff (!rst_n)
                (in_ok && dst_kernel) |=> (kind == '0 || (kind[B_KERNEL] && !kind[B_USER])));

            assert_one_kind_R9 : assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(kind[KIND_W-1:B_CALL]));

            assert_reset_clear_R11 : assert property (@(posedge clk)
                !rst_n |=> (kind == '0));
        end else begin : g_comb
            assign kind = res_d.kind;
        end
    endgenerate
endmodule

// File: tb/brk_classifier_test.sv
module brk_classifier_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 48;
    localparam int IW = 32;
    localparam int KW = 18;
    localparam int N_RAND = 3000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bytes_valid = 1'b0;
    logic [7:0]    op_first = '0, op_second = '0, modrm_byte = '0;
    logic [IW-1:0] rel_imm = '0;
    logic [AW-1:0] src_addr = '0, dst_addr = '0;
    logic          src_kernel = 1'b0, dst_kernel = 1'b0, abort_flag = 1'b0;
    logic [KW-1:0] kind;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brk_classifier #(.ADDR_W(AW), .IMM_W(IW), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .bytes_valid(bytes_valid),
        .op_first(op_first), .op_second(op_second), .modrm_byte(modrm_byte),
        .rel_imm(rel_imm), .src_addr(src_addr), .dst_addr(dst_addr),
        .src_kernel(src_kernel), .dst_kernel(dst_kernel),
        .abort_flag(abort_flag), .kind(kind)
    );

    function automatic int opcode_class(logic [7:0] a, logic [7:0] b, logic [7:0] m, logic [IW-1:0] imm);
        if (a == 8'h0F) begin
            if (b == 8'h05 || b == 8'h34) return 4;
            if (b == 8'h07 || b == 8'h35) return 5;
            if (b >= 8'h80 && b <= 8'h8F) return 8;
            return -1;
        end
        if ((a >= 8'h70 && a <= 8'h7F) || (a >= 8'hE0 && a <= 8'hE3)) return 8;
        if (a == 8'hC2 || a == 8'hC3 || a == 8'hCA || a == 8'hCB) return 3;
        if (a == 8'hCF) return 7;
        if (a >= 8'hCC && a <= 8'hCE) return 6;
        if (a >= 8'hE9 && a <= 8'hEB) return 9;
        if (a == 8'h9A) return 2;
        if (a == 8'hE8) return (imm == 0) ? 15 : 2;
        if (a == 8'hFF) begin
            int f = int'(m[5:3]);
            if (f == 2 || f == 3) return 11;
            if (f == 4 || f == 5) return 17;
        end
        return -1;
    endfunction

    function automatic logic [KW-1:0] model(logic bv, logic [7:0] a, logic [7:0] b, logic [7:0] m,
                                            logic [IW-1:0] imm, logic [AW-1:0] s, logic [AW-1:0] d,
                                            logic sk, logic dk, logic ab);
        logic [KW-1:0] r = '0;
        int c;
        int p = dk ? 1 : 0;
        if (!bv || s == 0 || d == 0) return r;
        if (ab) begin
            r[12] = 1'b1; r[p] = 1'b1; return r;
        end
        c = opcode_class(a, b, m, imm);
        if (!sk && dk && c != 4 && c != 6) c = 10;
        if (c < 0) return r;
        r[c] = 1'b1;
        r[p] = 1'b1;
        return r;
    endfunction

    task automatic check(input logic [KW-1:0] exp, input string tag);
        checks++;
        if (kind !== exp) begin
            failures++;
            $display("FAIL %s: kind=%05h expected=%05h (op %02h %02h modrm %02h)",
                     tag, kind, exp, op_first, op_second, modrm_byte);
        end
    endtask

    task automatic drive(input logic bv, input logic [7:0] a, input logic [7:0] b, input logic [7:0] m,
                         input logic [IW-1:0] imm, input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input logic sk, input logic dk, input logic ab, input string tag);
        logic [KW-1:0] exp;
        @(negedge clk);
        bytes_valid = bv; op_first = a; op_second = b; modrm_byte = m; rel_imm = imm;
        src_addr = s; dst_addr = d; src_kernel = sk; dst_kernel = dk; abort_flag = ab;
        exp = model(bv, a, b, m, imm, s, d, sk, dk, ab);
        @(posedge clk);
        #1;
        check(exp, tag);
    endtask

    function automatic logic [7:0] pick_first();
        logic [7:0] pool [0:15] = '{8'h0F, 8'h70, 8'h7F, 8'hE0, 8'hE3, 8'hC2, 8'hCB, 8'hCF,
                                    8'hCC, 8'hCE, 8'hE9, 8'hEB, 8'h9A, 8'hE8, 8'hFF, 8'h90};
        if ($urandom_range(0, 4) == 0) return 8'($urandom);
        return pool[$urandom_range(0, 15)];
    endfunction

    function automatic logic [7:0] pick_second();
        logic [7:0] pool [0:5] = '{8'h05, 8'h34, 8'h07, 8'h35, 8'h80, 8'h8F};
        if ($urandom_range(0, 2) == 0) return 8'($urandom);
        return pool[$urandom_range(0, 5)];
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic [AW-1:0] A1 = 48'h0000_0040_1000;
        logic [AW-1:0] A2 = 48'hFFFF_8000_2000;
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        bytes_valid = 1'b1; op_first = 8'hE9; src_addr = A1; dst_addr = A2;
        repeat (3) @(posedge clk);
        #1; check('0, "R11 reset holds zero");
        @(negedge clk); rst_n = 1'b1;

        // R1: gate beats abort
        drive(1'b1, 8'hE9, 0, 0, 5, '0, A2, 0, 0, 1'b1, "R1 zero src with abort");
        drive(1'b1, 8'hC3, 0, 0, 5, A1, '0, 0, 0, 1'b0, "R1 zero dst");
        drive(1'b0, 8'hC3, 0, 0, 5, A1, A2, 0, 0, 1'b0, "R1 no bytes");
        // R2
        drive(1'b1, 8'hC3, 0, 0, 5, A1, A2, 0, 1, 1'b1, "R2 abort kernel");
        drive(1'b1, 8'h90, 0, 0, 5, A1, A2, 0, 0, 1'b1, "R2 abort user");
        // R3
        drive(1'b1, 8'h0F, 8'h05, 0, 5, A1, A2, 0, 0, 0, "R3 syscall");
        drive(1'b1, 8'h0F, 8'h35, 0, 5, A1, A2, 1, 1, 0, "R3 sysexit");
        drive(1'b1, 8'h0F, 8'h8F, 0, 5, A1, A2, 0, 0, 0, "R3 cond 8F");
        drive(1'b1, 8'h0F, 8'h90, 0, 5, A1, A2, 0, 0, 0, "R3 unknown 0F 90");
        // R4, R5, R6
        drive(1'b1, 8'hE3, 0, 0, 5, A1, A2, 0, 0, 0, "R4 loop cond");
        drive(1'b1, 8'hCA, 0, 0, 5, A1, A2, 1, 1, 0, "R5 far ret");
        drive(1'b1, 8'hCF, 0, 0, 5, A1, A2, 1, 0, 0, "R5 iret to user");
        drive(1'b1, 8'hCD, 0, 0, 5, A1, A2, 0, 0, 0, "R5 int");
        drive(1'b1, 8'hE8, 0, 0, 0, A1, A2, 0, 0, 0, "R6 zero call");
        drive(1'b1, 8'hE8, 0, 0, 32'h8000_0000, A1, A2, 0, 0, 0, "R6 rel call");
        drive(1'b1, 8'h9A, 0, 0, 0, A1, A2, 1, 1, 0, "R6 far call");
        drive(1'b1, 8'hEA, 0, 0, 0, A1, A2, 0, 0, 0, "R6 jmp");
        // R7: every reg field
        for (int f = 0; f < 8; f++)
            drive(1'b1, 8'hFF, 0, 8'(f << 3) | 8'hC7, 5, A1, A2, 1, 1, 0, "R7 modrm field");
        // R8: user to kernel
        drive(1'b1, 8'h0F, 8'h34, 0, 5, A1, A2, 0, 1, 0, "R8 sysenter kept");
        drive(1'b1, 8'hCC, 0, 0, 5, A1, A2, 0, 1, 0, "R8 int kept");
        drive(1'b1, 8'hE9, 0, 0, 5, A1, A2, 0, 1, 0, "R8 jmp to irq");
        drive(1'b1, 8'h90, 0, 0, 5, A1, A2, 0, 1, 0, "R8 unknown to irq");
        // R9, R10
        drive(1'b1, 8'h75, 0, 0, 5, A1, A2, 1, 1, 0, "R9 kernel priv bit");
        drive(1'b1, 8'h90, 0, 0, 5, A1, A2, 1, 1, 0, "R10 unknown no priv");
        drive(1'b1, 8'hFF, 0, 8'h00, 5, A1, A2, 0, 0, 0, "R10 FF /0 no priv");

        for (int i = 0; i < N_RAND; i++) begin
            logic [AW-1:0] s = AW'({$urandom, $urandom});
            logic [AW-1:0] d = AW'({$urandom, $urandom});
            if ($urandom_range(0, 15) == 0) s = '0;
            if ($urandom_range(0, 15) == 0) d = '0;
            drive($urandom_range(0, 15) != 0, pick_first(), pick_second(), 8'($urandom),
                  ($urandom_range(0, 3) == 0) ? '0 : IW'($urandom), s, d,
                  1'($urandom), 1'($urandom), $urandom_range(0, 9) == 0,
                  "R3 R4 R5 R6 R7 R8 R9 random");
        end

        // R11: reset clears a live result
        drive(1'b1, 8'hC3, 0, 0, 5, A1, A2, 0, 0, 0, "R5 before reset");
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; check('0, "R11 reset clears");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule